// File: doc/BRIEF.md
# SPI Data Register Queue Aligner

This block is the register-side data path of an SPI master. On one side it faces a 32-bit register bus. On the other side it faces a serial shift engine, and a valid/ready handshake carries characters to and from that engine in each direction. Software writes transmit words into a four-entry transmit queue and reads received words from a four-entry receive queue.

A character is between 2 and 16 bits long, or a full 32 bits. A four-bit length code (bits minus one, with 0 meaning 32) and a bit-order flag decide where a character sits inside the 32-bit register word. The block also reports whether the transmit queue has room and whether the receive queue holds data. It holds a two-bit active-low slave select that only software changes.

Before a transmit character goes to the engine, the block extracts it from the written word and right-aligns it. A received character comes from the engine right-aligned, and the block places it in the register word around a fixed half-word split at bit 16 before queuing it. Clock generation, pin shifting, interrupts and DMA are not part of this block.

Top module: `spi_dq_aligner`

## Requirements
- R1: A bus write with `bus_sel`=0 pushes into the transmit queue only while `flag_nf` is 1. A write made while the queue holds 4 entries is discarded and never reaches `tx_char`.
- R2: With `cfg_rev`=0 and a character of N bits, `tx_char` equals bits N-1..0 of the written word, and bits N and above are zero.
- R3: With `cfg_rev`=1 and a character of N bits, `tx_char` equals bits 31..32-N of the written word shifted down to bit 0, and bits N and above are zero.
- R4: The character length N is `cfg_len`+1 for `cfg_len` of 1 to 15, and N is 32 for `cfg_len`=0. With N=32, received words are returned unchanged.
- R5: For `cfg_len`≠0 and `cfg_rev`=0, the low N bits of `rx_char` are read back with the character's top bit at bit 15, and all other bits read zero. For example, eight ones read back as 0x0000FF00.
- R6: For `cfg_len`≠0 and `cfg_rev`=1, the low N bits of `rx_char` are read back with the character's bit 0 at bit 16, and all other bits read zero. For example, eight ones read back as 0x00FF0000.
- R7: `flag_nf` is 1 while the transmit queue holds fewer than 4 entries. `flag_ne` is 1 while the receive queue holds at least one entry. `rx_ready` is 1 while the receive queue holds fewer than 4 entries.
- R8: A bus read with `bus_sel`=1 returns the oldest received word and removes it in the same cycle. A read with `bus_sel`=1 while the receive queue is empty returns 0 and leaves the queue unchanged.
- R9: `ss_n` resets to 2'b11. It changes only on a bus write with `bus_sel`=2, which loads `bus_wdata[1:0]`. A read with `bus_sel`=2 returns `ss_n` in bits 1:0 and zero in bits 31:2.
- R10: Both queues deliver entries in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_len | input | 4 | Character length code (bits minus one, 0 means 32) |
| cfg_rev | input | 1 | Bit-order flag for register placement |
| bus_sel | input | 2 | Register select: 0 transmit, 1 receive, 2 slave select, 3 none |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data |
| flag_nf | output | 1 | Transmit queue not full |
| flag_ne | output | 1 | Receive queue not empty |
| ss_n | output | 2 | Slave select lines, active low |
| tx_valid | output | 1 | Transmit character available to the shift engine |
| tx_ready | input | 1 | Shift engine takes the transmit character |
| tx_char | output | 32 | Right-aligned transmit character |
| rx_valid | input | 1 | Shift engine offers a received character |
| rx_ready | output | 1 | Receive queue can accept a character |
| rx_char | input | 32 | Right-aligned received character |

## Verification
The hardest conditions to reach are at the queue edges. The first is a fifth transmit write that lands while the queue is full. The second is a receive read from an empty queue that must not disturb the pointers. To reach the first, the bench holds back `tx_ready` while it writes five distinct words. It then drains the queue and confirms that only the first four come out, in order. For the empty read, the bench drains the receive queue and reads once more. It then pushes one new character and checks that this character, not a stale one, is what the next read returns. Placement is covered by a sweep over every length code and both bit orders, with several data patterns whose upper bits are deliberately non-zero.

// File: rtl/spi_dq_pkg.sv
package spi_dq_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned LENW = 4;
  localparam int unsigned HALF = DW / 2;
  localparam int unsigned NBW  = $clog2(DW) + 1;

  typedef enum logic [1:0] {
    SEL_TX   = 2'd0,
    SEL_RX   = 2'd1,
    SEL_SS   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // character length in bits from the length code
  function automatic logic [NBW-1:0] char_bits(input logic [LENW-1:0] len);
    if (len == '0) return NBW'(DW);
    return NBW'(len) + NBW'(1);
  endfunction

  function automatic logic [DW-1:0] char_mask(input logic [NBW-1:0] nb);
    if (nb >= NBW'(DW)) return '1;
    return (DW'(1) << nb) - DW'(1);
  endfunction
endpackage

// File: rtl/spi_dq_fifo.sv
module spi_dq_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         not_full,
  output logic         not_empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign not_full  = (cnt_q < CW'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign do_push   = push && not_full;
  assign do_pop    = pop && not_empty;
  assign rdata     = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    if (do_pop)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_full && push && !pop) |=> (!not_full && $stable(wptr_q)));
  p_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && pop && !push) |=> ($stable(rptr_q) && !not_empty));
  p_ne_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(not_empty) |-> $past(push));
endmodule

// File: rtl/spi_dq_tx_align.sv
module spi_dq_tx_align
  import spi_dq_pkg::*;
(
  input  logic [DW-1:0]   word,
  input  logic [LENW-1:0] len,
  input  logic            rev,
  output logic [DW-1:0]   chr
);
  logic [NBW-1:0] nb;
  logic [DW-1:0]  mask;

  always_comb begin
    nb   = char_bits(len);
    mask = char_mask(nb);
    if (rev) chr = word >> (NBW'(DW) - nb);
    else     chr = word & mask;
  end
endmodule

// File: rtl/spi_dq_rx_place.sv
module spi_dq_rx_place
  import spi_dq_pkg::*;
(
  input  logic [DW-1:0]   chr,
  input  logic [LENW-1:0] len,
  input  logic            rev,
  output logic [DW-1:0]   word
);
  logic [NBW-1:0] nb;
  logic [DW-1:0]  clean;

  always_comb begin
    nb    = char_bits(len);
    clean = chr & char_mask(nb);
    if (len == '0) word = clean;
    else if (rev)  word = clean << HALF;
    else           word = clean << (NBW'(HALF) - nb);
  end
endmodule

// File: rtl/spi_dq_aligner.sv
module spi_dq_aligner
  import spi_dq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SSW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LENW-1:0] cfg_len,
  input  logic            cfg_rev,
  input  logic [1:0]      bus_sel,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            flag_nf,
  output logic            flag_ne,
  output logic [SSW-1:0]  ss_n,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [DW-1:0]   tx_char,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [DW-1:0]   rx_char
);
  reg_sel_e       sel;
  logic [1:0]     rst_sync_q;
  logic           rst_q_n;
  logic [DW-1:0]  tx_aligned, rx_placed, rx_head;
  logic           tx_push, rx_pop, ss_wr;
  logic [SSW-1:0] ss_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign sel     = reg_sel_e'(bus_sel);
  assign tx_push = bus_wr && (sel == SEL_TX);
  assign rx_pop  = bus_rd && (sel == SEL_RX);
  assign ss_wr   = bus_wr && (sel == SEL_SS);

  spi_dq_tx_align u_txa (.word(bus_wdata), .len(cfg_len), .rev(cfg_rev), .chr(tx_aligned));
  spi_dq_rx_place u_rxp (.chr(rx_char), .len(cfg_len), .rev(cfg_rev), .word(rx_placed));

  spi_dq_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_q_n), .push(tx_push), .wdata(tx_aligned),
    .pop(tx_ready), .rdata(tx_char), .not_full(flag_nf), .not_empty(tx_valid));

  spi_dq_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_q_n), .push(rx_valid), .wdata(rx_placed),
    .pop(rx_pop), .rdata(rx_head), .not_full(rx_ready), .not_empty(flag_ne));

  always_comb begin
    ss_d = ss_n;
    if (ss_wr) ss_d = bus_wdata[SSW-1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ss_n <= '1;
    else          ss_n <= ss_d;
  end

  always_comb begin
    unique case (sel)
      SEL_RX:  bus_rdata = flag_ne ? rx_head : '0;
      SEL_SS:  bus_rdata = DW'(ss_n);
      default: bus_rdata = '0;
    endcase
  end

  p_ss_hold_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ss_wr |=> $stable(ss_n));
  p_rx_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rx_pop && !flag_ne) |-> (bus_rdata == '0));
  p_ss_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel == SEL_SS) |-> (bus_rdata[DW-1:SSW] == '0));
endmodule

// File: tb/tb_spi_dq_aligner.sv
module tb_spi_dq_aligner;
  localparam time TCLK = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_len;
  logic        cfg_rev;
  logic [1:0]  bus_sel;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        flag_nf, flag_ne;
  logic [1:0]  ss_n;
  logic        tx_valid, tx_ready;
  logic [31:0] tx_char;
  logic        rx_valid, rx_ready;
  logic [31:0] rx_char;

  int n_tests = 0;
  int n_fail  = 0;

  always #(TCLK/2) clk = ~clk;

  spi_dq_aligner dut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_rev(cfg_rev),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_nf(flag_nf), .flag_ne(flag_ne), .ss_n(ss_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_char(tx_char),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_char(rx_char));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [3:0] len);
    return (len == 0) ? 32 : int'(len) + 1;
  endfunction

  function automatic logic [31:0] mk(input int nb);
    return (nb >= 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
  endfunction

  function automatic logic [31:0] exp_tx(input logic [31:0] w, input logic [3:0] len, input logic rev);
    int nb = nbits(len);
    return rev ? (w >> (32 - nb)) : (w & mk(nb));
  endfunction

  function automatic logic [31:0] exp_rx(input logic [31:0] c, input logic [3:0] len, input logic rev);
    int nb = nbits(len);
    logic [31:0] m = c & mk(nb);
    if (len == 0) return m;
    return rev ? (m << 16) : (m << (16 - nb));
  endfunction

  task automatic bus_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); bus_sel = s; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_sel = 2'd3;
  endtask

  task automatic tx_one(input logic [31:0] w, input string req);
    bus_write(2'd0, w);
    #1;
    chk(req, {31'd0, tx_valid}, 32'd1);
    chk(req, tx_char, exp_tx(w, cfg_len, cfg_rev));
    tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic rx_push(input logic [31:0] c);
    @(negedge clk); rx_valid = 1'b1; rx_char = c;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic rx_read(output logic [31:0] d);
    bus_sel = 2'd1; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; bus_sel = 2'd3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; cfg_len = 4'd7; cfg_rev = 1'b0; bus_sel = 2'd3;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_char = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // reset state
    chk("R9 reset ss_n", {30'd0, ss_n}, 32'h3);
    chk("R7 reset nf", {31'd0, flag_nf}, 32'd1);
    chk("R7 reset ne", {31'd0, flag_ne}, 32'd0);
    chk("R7 reset rx_ready", {31'd0, rx_ready}, 32'd1);
    chk("R1 reset tx_valid", {31'd0, tx_valid}, 32'd0);

    // worked example
    cfg_len = 4'd7; cfg_rev = 1'b0;
    rx_push(32'hFFFF_FFFF); @(negedge clk); rx_read(d);
    chk("R5 eight ones", d, 32'h0000_FF00);
    cfg_rev = 1'b1;
    rx_push(32'h0000_00FF); @(negedge clk); rx_read(d);
    chk("R6 eight ones", d, 32'h00FF_0000);

    // sweep of every length and bit order
    for (int l = 0; l < 16; l++) begin
      for (int r = 0; r < 2; r++) begin
        cfg_len = 4'(l); cfg_rev = 1'(r);
        for (int k = 0; k < 4; k++) begin
          logic [31:0] pat = 32'hA5C3_96E1 ^ (32'(k) * 32'h9E37_79B9);
          string rq;
          rq = (l == 0) ? "R4 tx 32-bit" : (r == 0 ? "R2 tx rev0" : "R3 tx rev1");
          tx_one(pat, rq);
          rq = (l == 0) ? "R4 rx 32-bit" : (r == 0 ? "R5 rx rev0" : "R6 rx rev1");
          rx_push(~pat);
          @(negedge clk);
          rx_read(d);
          chk(rq, d, exp_rx(~pat, cfg_len, cfg_rev));
        end
      end
    end

    // transmit queue full, fifth write discarded, order preserved
    cfg_len = 4'd15; cfg_rev = 1'b0;
    for (int i = 0; i < 5; i++) begin
      #1 chk("R7 nf before write", {31'd0, flag_nf}, (i < 4) ? 32'd1 : 32'd0);
      bus_write(2'd0, 32'h1000 + 32'(i));
    end
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R10 tx order", tx_char, 32'h1000 + 32'(i));
      tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    end
    #1 chk("R1 fifth write dropped", {31'd0, tx_valid}, 32'd0);

    // receive queue full, drain, empty read
    cfg_len = 4'd0;
    for (int i = 0; i < 4; i++) rx_push(32'hBEEF_0000 + 32'(i));
    #1 chk("R7 rx_ready full", {31'd0, rx_ready}, 32'd0);
    rx_push(32'hDEAD_DEAD);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rx_read(d);
      chk("R10 rx order", d, 32'hBEEF_0000 + 32'(i));
    end
    #1 chk("R7 ne after drain", {31'd0, flag_ne}, 32'd0);
    rx_read(d);
    chk("R8 empty read zero", d, 32'd0);
    rx_push(32'h1234_5678); @(negedge clk);
    rx_read(d);
    chk("R8 pointers kept", d, 32'h1234_5678);
    #1 chk("R8 popped", {31'd0, flag_ne}, 32'd0);

    // slave select
    bus_write(2'd2, 32'hFFFF_FFF2);
    #1 chk("R9 ss write", {30'd0, ss_n}, 32'h2);
    bus_write(2'd0, 32'h0000_0001);
    bus_write(2'd3, 32'h0000_0001);
    #1 chk("R9 ss untouched", {30'd0, ss_n}, 32'h2);
    bus_sel = 2'd2; #1 chk("R9 ss readback", bus_rdata, 32'h2);
    @(negedge clk); bus_sel = 2'd3;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule